// File: doc/BRIEF.md
# Trigger Busy Generator

This block produces the busy level that a readout system returns to its trigger source. Every level-0 trigger pulse loads a hold timer with a host-programmed cycle count, and busy stays high while that timer runs. The block also keeps a count of front-end event buffers in use: each accepted trigger claims one, and each release pulse from the event-matching logic frees one. Whenever the in-use count has reached the host-configured number of buffers, busy is held high, however long ago the last trigger arrived.

Busy is therefore the OR of the hold timer and the buffers-full condition. A cycle counter accumulates the total time spent busy. It saturates at its all-ones value and is zeroed by a host clear strobe. The host reads the counter as an upper and a lower half. Trigger decoding happens upstream and is not part of this block.

Top module: `trig_busy_gen`

## Requirements
- R1: While reset is held, and until the first qualifying input after it, busy is low, the in-use buffer count is 0 and both busy-time halves are 0.
- R2: A trigger sampled at a clock edge with hold value H (H > 0) makes the timer contribution to busy high for exactly the H cycles that follow that edge. A trigger with H = 0 adds no hold time.
- R3: A trigger that arrives while the hold timer is still running reloads the timer with the current hold value, so the hold time is counted from the newest trigger.
- R4: A trigger adds one to the in-use count only if the count is below the configured buffer number in that cycle. A release subtracts one only if the count is above 0. When both arrive in the same cycle, both rules apply independently.
- R5: Busy is high in every cycle in which the in-use count is greater than or equal to the configured buffer number, even after the hold timer has run out. A configured number of 0 therefore keeps busy permanently high.
- R6: At each clock edge where busy is high and no clear is requested, the busy-time counter goes up by one. The upper-half output carries counter bits [2*HALF_W-1:HALF_W] and the lower-half output carries bits [HALF_W-1:0].
- R7: With the saturating variant (the default), the busy-time counter stops at all ones and stays there while busy remains high.
- R8: A clear strobe sampled at an edge sets the busy-time counter to 0 at that edge, and takes priority over an increment in the same cycle.
- R9: A release pulse while the in-use count is 0 is ignored: the count stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l0_trig_i | input | 1 | Level-0 trigger pulse, one cycle per trigger |
| buf_rel_i | input | 1 | One-cycle pulse: one front-end buffer has been freed |
| cfg_hold_i | input | HOLD_W | Hold time in cycles, loaded on each trigger |
| cfg_nbuf_i | input | BUF_W | Number of front-end buffers available |
| bt_clr_i | input | 1 | Host strobe that clears the busy-time counter |
| busy_o | output | 1 | Busy level returned to the trigger source |
| bufs_used_o | output | BUF_W | Front-end buffers currently in use |
| bt_hi_o | output | HALF_W | Upper half of the busy-time counter |
| bt_lo_o | output | HALF_W | Lower half of the busy-time counter |

## Verification
The bench builds the block with HOLD_W = 6, BUF_W = 3 and HALF_W = 4, which gives an 8-bit busy-time counter. Saturation at 255 can then be reached in a few hundred cycles of held busy. Buffer counts of 0 to 7 let the bench hit full, empty and a lowered limit many times within a short random run. Hold values up to 11 keep retriggering inside a running hold window frequent. Directed runs pin down the exact hold length, reload, zero hold, release at empty, clear priority and saturation.

// File: rtl/tbg_pkg.sv
package tbg_pkg;
   // Busy-time counter behaviour at its top value
   typedef enum logic [0:0] {
      BT_WRAP     = 1'b0,
      BT_SATURATE = 1'b1
   } bt_mode_e;
endpackage

// File: rtl/tbg_hold_timer.sv
module tbg_hold_timer #(
   parameter int HOLD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_i,
   input  logic [HOLD_W-1:0] load_val_i,
   output logic              active_o
);
   logic [HOLD_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (trig_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - HOLD_W'(1);
      end
   end

   assign active_o = (cnt_q != '0);

   // R3
   reload_on_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_i |=> (cnt_q == $past(load_val_i)));

   // R2
   count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_i && active_o) |=> (cnt_q == $past(cnt_q) - HOLD_W'(1)));

   // R2
   idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_i && !active_o) |=> !active_o);
endmodule

// File: rtl/tbg_buf_track.sv
module tbg_buf_track #(
   parameter int BUF_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_i,
   input  logic             release_i,
   input  logic [BUF_W-1:0] limit_i,
   output logic [BUF_W-1:0] used_o,
   output logic             full_o
);
   logic [BUF_W-1:0] used_q;
   logic             inc, dec;

   assign full_o = (used_q >= limit_i);
   assign inc    = take_i && !full_o;
   assign dec    = release_i && (used_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         used_q <= '0;
      end else begin
         unique case ({inc, dec})
            2'b10:   used_q <= used_q + BUF_W'(1);
            2'b01:   used_q <= used_q - BUF_W'(1);
            default: used_q <= used_q;
         endcase
      end
   end

   assign used_o = used_q;

   // R9
   empty_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (release_i && !take_i && used_q == '0) |=> (used_q == '0));

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!take_i && !release_i) |=> $stable(used_q));

   // R4
   no_claim_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && !release_i) |=> (used_q == $past(used_q)));
endmodule

// File: rtl/tbg_busy_accum.sv
module tbg_busy_accum #(
   parameter int               HALF_W  = 16,
   parameter tbg_pkg::bt_mode_e BT_MODE = tbg_pkg::BT_SATURATE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic              clr_i,
   output logic [HALF_W-1:0] hi_o,
   output logic [HALF_W-1:0] lo_o
);
   localparam int CNT_W = 2 * HALF_W;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;

   generate
      if (BT_MODE == tbg_pkg::BT_SATURATE) begin : g_sat
         assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);

         // R7
         sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));
      end else begin : g_wrap
         assign cnt_inc = cnt_q + CNT_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         cnt_q <= '0;
      end else if (busy_i) begin
         cnt_q <= cnt_inc;
      end
   end

   assign hi_o = cnt_q[CNT_W-1:HALF_W];
   assign lo_o = cnt_q[HALF_W-1:0];

   // R8
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0));

   // R6
   idle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/trig_busy_gen.sv
module trig_busy_gen #(
   parameter int                HOLD_W  = 16,
   parameter int                BUF_W   = 8,
   parameter int                HALF_W  = 16,
   parameter tbg_pkg::bt_mode_e BT_MODE = tbg_pkg::BT_SATURATE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l0_trig_i,
   input  logic              buf_rel_i,
   input  logic [HOLD_W-1:0] cfg_hold_i,
   input  logic [BUF_W-1:0]  cfg_nbuf_i,
   input  logic              bt_clr_i,
   output logic              busy_o,
   output logic [BUF_W-1:0]  bufs_used_o,
   output logic [HALF_W-1:0] bt_hi_o,
   output logic [HALF_W-1:0] bt_lo_o
);
   generate
      if (HOLD_W < 1 || HOLD_W > 32) begin : g_bad_hold
         initial $fatal(1, "HOLD_W must be within 1..32");
      end
      if (BUF_W < 1 || BUF_W > 16) begin : g_bad_buf
         initial $fatal(1, "BUF_W must be within 1..16");
      end
      if (HALF_W < 2 || HALF_W > 32) begin : g_bad_half
         initial $fatal(1, "HALF_W must be within 2..32");
      end
   endgenerate

   logic hold_active;
   logic bufs_full;

   tbg_hold_timer #(.HOLD_W(HOLD_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_i     (l0_trig_i),
      .load_val_i (cfg_hold_i),
      .active_o   (hold_active)
   );

   tbg_buf_track #(.BUF_W(BUF_W)) u_bufs (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_i    (l0_trig_i),
      .release_i (buf_rel_i),
      .limit_i   (cfg_nbuf_i),
      .used_o    (bufs_used_o),
      .full_o    (bufs_full)
   );

   assign busy_o = hold_active | bufs_full;

   tbg_busy_accum #(.HALF_W(HALF_W), .BT_MODE(BT_MODE)) u_accum (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy_i (busy_o),
      .clr_i  (bt_clr_i),
      .hi_o   (bt_hi_o),
      .lo_o   (bt_lo_o)
   );

   // R5
   full_forces_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bufs_used_o >= cfg_nbuf_i) |-> busy_o);

   // R2
   trig_gives_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l0_trig_i && cfg_hold_i != '0) |=> busy_o);
endmodule

// File: tb/tb_trig_busy_gen.sv
`timescale 1ns/100ps
module tb_trig_busy_gen;
   localparam int HOLD_W = 6;
   localparam int BUF_W  = 3;
   localparam int HALF_W = 4;
   localparam int CNT_MAX = (1 << (2*HALF_W)) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              l0_trig_i = 1'b0;
   logic              buf_rel_i = 1'b0;
   logic [HOLD_W-1:0] cfg_hold_i = '0;
   logic [BUF_W-1:0]  cfg_nbuf_i = '0;
   logic              bt_clr_i = 1'b0;
   logic              busy_o;
   logic [BUF_W-1:0]  bufs_used_o;
   logic [HALF_W-1:0] bt_hi_o, bt_lo_o;

   trig_busy_gen #(.HOLD_W(HOLD_W), .BUF_W(BUF_W), .HALF_W(HALF_W)) dut (
      .clk(clk), .rst_n(rst_n), .l0_trig_i(l0_trig_i), .buf_rel_i(buf_rel_i),
      .cfg_hold_i(cfg_hold_i), .cfg_nbuf_i(cfg_nbuf_i), .bt_clr_i(bt_clr_i),
      .busy_o(busy_o), .bufs_used_o(bufs_used_o), .bt_hi_o(bt_hi_o), .bt_lo_o(bt_lo_o)
   );

   always #2.5 clk = ~clk;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   int  m_hold = 0;
   int  m_used = 0;
   int  m_cnt  = 0;

   function automatic bit exp_busy();
      return (m_hold != 0) || (m_used >= int'(cfg_nbuf_i));
   endfunction

   function automatic int next_used(bit trig, bit rel);
      int u = m_used;
      if (trig && m_used < int'(cfg_nbuf_i)) u++;
      if (rel && m_used != 0) u--;
      return u;
   endfunction

   function automatic int next_cnt(bit busy, bit clr);
      if (clr) return 0;
      if (busy && m_cnt < CNT_MAX) return m_cnt + 1;
      return m_cnt;
   endfunction

   task automatic compare(string tag);
      int act_cnt = {bt_hi_o, bt_lo_o};
      n_chk++;
      if (busy_o !== exp_busy() || int'(bufs_used_o) != m_used || act_cnt != m_cnt) begin
         n_bad++;
         $display("FAIL %s: busy=%0b used=%0d bt=%0d expected busy=%0b used=%0d bt=%0d",
                  tag, busy_o, bufs_used_o, act_cnt, exp_busy(), m_used, m_cnt);
      end
   endtask

   // one clock: inputs already driven; model advances on the edge, compare 1 ns later
   task automatic tick(string tag);
      bit b = exp_busy();
      bit t = l0_trig_i, r = buf_rel_i, c = bt_clr_i;
      @(posedge clk);
      if (rst_n) begin
         m_cnt  = next_cnt(b, c);
         m_used = next_used(t, r);
         m_hold = t ? int'(cfg_hold_i) : ((m_hold != 0) ? m_hold - 1 : 0);
      end
      #1;
      compare(tag);
   endtask

   task automatic pulse(input bit t, input bit r, input bit c, string tag);
      l0_trig_i = t; buf_rel_i = r; bt_clr_i = c;
      tick(tag);
      l0_trig_i = 1'b0; buf_rel_i = 1'b0; bt_clr_i = 1'b0;
   endtask

   task automatic idle(int n, string tag);
      for (int i = 0; i < n; i++) tick(tag);
   endtask

   initial begin
      cfg_hold_i = 6'd5;
      cfg_nbuf_i = 3'd7;
      // R1: reset state
      idle(3, "R1");
      rst_n = 1'b1;
      idle(2, "R1");

      // R2: exact hold length for H=5
      pulse(1, 0, 0, "R2");
      idle(7, "R2");
      // R2: zero hold adds no busy
      cfg_hold_i = 6'd0;
      pulse(1, 0, 0, "R2");
      idle(3, "R2");
      cfg_hold_i = 6'd5;

      // R3: retrigger inside the window reloads the timer
      pulse(1, 0, 0, "R3");
      idle(3, "R3");
      pulse(1, 0, 0, "R3");
      idle(7, "R3");

      // R5: buffers full keeps busy after timeout
      cfg_nbuf_i = 3'd4;
      pulse(1, 0, 0, "R5");
      pulse(1, 0, 0, "R5");
      idle(10, "R5");
      // R4: trigger while full does not claim; simultaneous trigger and release
      pulse(1, 0, 0, "R4");
      pulse(1, 1, 0, "R4");
      pulse(0, 1, 0, "R4");
      idle(7, "R4");

      // R9: drain then release at zero
      for (int i = 0; i < 6; i++) pulse(0, 1, 0, "R9");
      idle(2, "R9");

      // R8: clear while busy wins over increment
      cfg_nbuf_i = 3'd0;
      idle(4, "R8");
      pulse(0, 0, 1, "R8");
      idle(2, "R8");

      // R7: saturation at all ones with busy held
      idle(300, "R7");
      if (m_cnt != CNT_MAX) begin
         n_bad++;
         $display("FAIL R7: model count %0d expected %0d", m_cnt, CNT_MAX);
      end
      n_chk++;
      pulse(0, 0, 1, "R8");

      // R6: constrained random mix
      void'($urandom(32'd1480));
      cfg_nbuf_i = 3'd5;
      for (int i = 0; i < 3000; i++) begin
         if (i % 250 == 0) begin
            cfg_hold_i = HOLD_W'($urandom % 12);
            cfg_nbuf_i = BUF_W'($urandom % 8);
         end
         l0_trig_i = ($urandom % 6) == 0;
         buf_rel_i = ($urandom % 5) == 0;
         bt_clr_i  = ($urandom % 151) == 0;
         tick("R6");
      end
      l0_trig_i = 1'b0; buf_rel_i = 1'b0; bt_clr_i = 1'b0;
      idle(2, "R6");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule